// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block receives stereo audio from a serial link in which the sender owns the clocks. The bit clock, the frame (left/right) clock and the data line come in as plain pins. A faster system clock oversamples them: a short synchronizer chain brings each pin into the system domain, and an edge detector marks the selected edge of the bit clock. On each marked edge the block takes one data bit and one frame-clock sample. A single shift engine turns that bit stream into words under one of four framing conventions. The convention is chosen by a 2-bit format code, and the sample width by a 2-bit word-length code. Two polarity inputs select which bit-clock edge samples and invert the sense of the frame clock.

Each completed word is tagged as left or right. A left word waits in a holding register. When the matching right word completes, both words are presented together on the outputs, aligned to the most significant end of a 32-bit field, and a one-cycle valid strobe marks the new pair. Configuration inputs are expected to change only while the block is held in reset.

Top module: `aud_serial_rx`

## Requirements
- R1: While reset is asserted, and after it is released until the first pair completes, `valid_o` is 0 and `left_o` and `right_o` read 0.
- R2: With `fmt_i` = 01 (left-justified), the bit taken on the first sampling edge at which the frame clock differs from its value at the previous sampling edge is the MSB of the new word. A high frame clock marks the left channel.
- R3: With `fmt_i` = 10 (I2S), the MSB is the bit taken one sampling edge after the frame-clock change. A low frame clock marks the left channel.
- R4: With `fmt_i` = 00 (right-justified), a word is formed from the last N bits received before a frame-clock change. Its LSB is the bit of the final sampling edge before the change. A high frame clock marks the left channel.
- R5: With `fmt_i` = 11 (DSP mode A), a rising frame clock marks frame start. The left MSB is taken one sampling edge later, and the right word's MSB follows on the edge after the left LSB, with no gap.
- R6: `wlen_i` selects N = 16 (00), 20 (01), 24 (10) or 32 (11). Each output word holds its N bits in bits 31 down to 32-N, and every lower bit is 0.
- R7: With `bclk_inv_i` = 0, data and frame clock are sampled on the rising bit-clock edge. With `bclk_inv_i` = 1, they are sampled on the falling edge. Outputs change only in the cycle after a sampling edge is detected.
- R8: `lr_inv_i` = 1 inverts the frame clock before any framing decision, so each format's channel sense and frame-start edge swap.
- R9: `valid_o` pulses high for exactly one system clock once per frame, after the right word completes and only if a left word completed before it. `left_o` and `right_o` hold their values between pulses.
- R10: Bits received in a frame half beyond the N bits of a word, or ahead of them in right-justified mode, have no effect on the output samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fmt_i | input | 2 | Framing code: 00 right-justified, 01 left-justified, 10 I2S, 11 DSP mode A |
| wlen_i | input | 2 | Word length code: 00=16, 01=20, 10=24, 11=32 bits |
| bclk_inv_i | input | 1 | 1 selects the falling bit-clock edge for sampling |
| lr_inv_i | input | 1 | 1 inverts the frame clock |
| bclk_i | input | 1 | Serial bit clock from the sender |
| lrclk_i | input | 1 | Serial frame (left/right) clock from the sender |
| sdata_i | input | 1 | Serial data, MSB first |
| left_o | output | 32 | Left sample, MSB-aligned |
| right_o | output | 32 | Right sample, MSB-aligned |
| valid_o | output | 1 | One-cycle strobe marking a new left/right pair |

## Verification
The hardest case to reach from the ports is a frame half longer than the word. In that case the word boundary is fixed by counted bits in three formats, but by the coming frame-clock change in right-justified mode. The stimulus therefore fills every unused bit slot with a non-zero filler pattern and runs half lengths both equal to and longer than the word, so a misplaced boundary shows up as wrong data. A DSP mode A frame is only a little longer than two words, and its right word has to start on the very next edge after the left LSB. Finally, every format is repeated with the inverted bit-clock edge and the inverted frame-clock sense, so the samples land on the edges that a normal configuration would skip.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  localparam int SAMPLE_W = 32;
  localparam int CNT_W    = $clog2(SAMPLE_W + 1);

  typedef enum logic [1:0] {
    FMT_RJ   = 2'b00,
    FMT_LJ   = 2'b01,
    FMT_I2S  = 2'b10,
    FMT_DSPA = 2'b11
  } rx_fmt_e;

  // Word length in bits for a word-length code.
  function automatic logic [CNT_W-1:0] wl_bits(input logic [1:0] code);
    case (code)
      2'b00:   wl_bits = CNT_W'(16);
      2'b01:   wl_bits = CNT_W'(20);
      2'b10:   wl_bits = CNT_W'(24);
      default: wl_bits = CNT_W'(32);
    endcase
  endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) begin
        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/aud_rx_edge.sv
module aud_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_s,
  input  logic inv,
  output logic edge_stb
);

  logic bclk_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_q <= 1'b0;
    else        bclk_q <= bclk_s;
  end

  always_comb begin
    rise     = bclk_s & ~bclk_q;
    fall     = ~bclk_s & bclk_q;
    edge_stb = inv ? fall : rise;
  end

endmodule

// File: rtl/aud_rx_framer.sv
module aud_rx_framer
  import aud_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                edge_stb,
  input  logic                lr_s,
  input  logic                dat_s,
  input  logic [1:0]          fmt,
  input  logic [1:0]          wlen,
  output logic                word_stb,
  output logic                word_left,
  output logic [SAMPLE_W-1:0] word
);

  logic                lr_prev_q, lr_prev_d;
  logic [SAMPLE_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                active_q, active_d;
  logic                ch_left_q, ch_left_d;
  logic                pend_q, pend_d;
  logic                pend_left_q, pend_left_d;

  rx_fmt_e             f;
  logic [CNT_W-1:0]    wl_n;
  logic [CNT_W-1:0]    sft;
  logic                trans, rise, begin_w;
  logic [SAMPLE_W-1:0] sh_new;

  always_comb begin
    f       = rx_fmt_e'(fmt);
    wl_n    = wl_bits(wlen);
    sft     = CNT_W'(SAMPLE_W) - wl_n;
    trans   = lr_s ^ lr_prev_q;
    rise    = lr_s & ~lr_prev_q;
    sh_new  = {sh_q[SAMPLE_W-2:0], dat_s};
    begin_w = ((f == FMT_LJ) && trans) || pend_q;

    lr_prev_d   = lr_s;
    sh_d        = sh_new;
    cnt_d       = cnt_q;
    active_d    = active_q;
    ch_left_d   = ch_left_q;
    pend_d      = pend_q;
    pend_left_d = pend_left_q;
    word_stb    = 1'b0;
    word_left   = 1'b0;
    word        = '0;

    if (edge_stb) begin
      if (f == FMT_RJ) begin
        // Word ends at the frame-clock change; this edge's bit is excluded.
        if (trans) begin
          word_stb  = 1'b1;
          word_left = lr_prev_q;
          word      = sh_q << sft;
        end
      end else begin
        if (begin_w) begin
          active_d  = 1'b1;
          cnt_d     = CNT_W'(1);
          ch_left_d = (f == FMT_LJ) ? lr_s : pend_left_q;
          pend_d    = 1'b0;
        end else if (active_q) begin
          if (cnt_q == wl_n - CNT_W'(1)) begin
            word_stb  = 1'b1;
            word_left = ch_left_q;
            word      = sh_new << sft;
            active_d  = 1'b0;
            if ((f == FMT_DSPA) && ch_left_q) begin
              pend_d      = 1'b1;
              pend_left_d = 1'b0;
            end
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        if ((f == FMT_I2S) && trans) begin
          pend_d      = 1'b1;
          pend_left_d = ~lr_s;
        end
        if ((f == FMT_DSPA) && rise) begin
          pend_d      = 1'b1;
          pend_left_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_prev_q   <= 1'b0;
      sh_q        <= '0;
      cnt_q       <= '0;
      active_q    <= 1'b0;
      ch_left_q   <= 1'b0;
      pend_q      <= 1'b0;
      pend_left_q <= 1'b0;
    end else if (edge_stb) begin
      lr_prev_q   <= lr_prev_d;
      sh_q        <= sh_d;
      cnt_q       <= cnt_d;
      active_q    <= active_d;
      ch_left_q   <= ch_left_d;
      pend_q      <= pend_d;
      pend_left_q <= pend_left_d;
    end
  end

endmodule

// File: rtl/aud_rx_pair.sv
module aud_rx_pair
  import aud_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_stb,
  input  logic                word_left,
  input  logic [SAMPLE_W-1:0] word,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);

  logic [SAMPLE_W-1:0] hold_q, hold_d;
  logic                have_q, have_d;
  logic [SAMPLE_W-1:0] left_q, left_d, right_q, right_d;
  logic                valid_q, valid_d;
  logic                out_en;

  always_comb begin
    hold_d  = hold_q;
    have_d  = have_q;
    left_d  = left_q;
    right_d = right_q;
    valid_d = 1'b0;
    out_en  = 1'b0;
    if (word_stb) begin
      if (word_left) begin
        hold_d = word;
        have_d = 1'b1;
      end else if (have_q) begin
        left_d  = hold_q;
        right_d = word;
        valid_d = 1'b1;
        have_d  = 1'b0;
        out_en  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      have_q  <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (word_stb) begin
        hold_q <= hold_d;
        have_q <= have_d;
      end
      if (out_en) begin
        left_q  <= left_d;
        right_q <= right_d;
      end
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          fmt_i,
  input  logic [1:0]          wlen_i,
  input  logic                bclk_inv_i,
  input  logic                lr_inv_i,
  input  logic                bclk_i,
  input  logic                lrclk_i,
  input  logic                sdata_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);

  localparam int PIN_W = 3;

  logic [1:0]          rst_pipe_q;
  logic                srst_n;
  logic [PIN_W-1:0]    pins_s;
  logic                edge_stb;
  logic                lr_s;
  logic                word_stb, word_left;
  logic [SAMPLE_W-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign srst_n = rst_pipe_q[1];

  aud_rx_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst_n(srst_n),
    .d_i  ({bclk_i, lrclk_i, sdata_i}),
    .q_o  (pins_s)
  );

  assign lr_s = pins_s[1] ^ lr_inv_i;

  aud_rx_edge i_edge (
    .clk     (clk),
    .rst_n   (srst_n),
    .bclk_s  (pins_s[2]),
    .inv     (bclk_inv_i),
    .edge_stb(edge_stb)
  );

  aud_rx_framer i_framer (
    .clk      (clk),
    .rst_n    (srst_n),
    .edge_stb (edge_stb),
    .lr_s     (lr_s),
    .dat_s    (pins_s[0]),
    .fmt      (fmt_i),
    .wlen     (wlen_i),
    .word_stb (word_stb),
    .word_left(word_left),
    .word     (word)
  );

  aud_rx_pair i_pair (
    .clk      (clk),
    .rst_n    (srst_n),
    .word_stb (word_stb),
    .word_left(word_left),
    .word     (word),
    .left_o   (left_o),
    .right_o  (right_o),
    .valid_o  (valid_o)
  );

endmodule

// File: rtl/aud_rx_chk.sv
module aud_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        edge_stb,
  input logic [1:0]  wlen_i,
  input logic        valid_o,
  input logic [31:0] left_o,
  input logic [31:0] right_o
);

  assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  assert_zero_fill16_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && wlen_i == 2'b00) |-> (left_o[15:0] == 16'h0 && right_o[15:0] == 16'h0));

  assert_zero_fill20_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && wlen_i == 2'b01) |-> (left_o[11:0] == 12'h0 && right_o[11:0] == 12'h0));

  assert_zero_fill24_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && wlen_i == 2'b10) |-> (left_o[7:0] == 8'h0 && right_o[7:0] == 8'h0));

  assert_after_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(edge_stb));

endmodule

bind aud_serial_rx aud_rx_chk i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .edge_stb(edge_stb),
  .wlen_i  (wlen_i),
  .valid_o (valid_o),
  .left_o  (left_o),
  .right_o (right_o)
);

// File: tb/test_aud_serial_rx.sv
module test_aud_serial_rx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt_c = 2'b01;
  logic [1:0]  wl_c = 2'b10;
  logic        inv_c = 1'b0;
  logic        lri_c = 1'b0;
  logic        bclk = 1'b0;
  logic        lrclk = 1'b0;
  logic        sdata = 1'b0;
  logic [31:0] left_o, right_o;
  logic        valid_o;

  int          h_c = 32;
  int          n_checks = 0;
  int          n_fail = 0;
  int          n_valid = 0;
  int          frame_id = 0;
  string       cur_req = "R2";
  logic [31:0] exp_l[$];
  logic [31:0] exp_r[$];
  logic [31:0] held_l = '0;
  logic [31:0] held_r = '0;

  localparam logic [31:0] FILL = 32'hD1B5_4A32;

  always #10 clk = ~clk;

  aud_serial_rx i_aud_serial_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt_i     (fmt_c),
    .wlen_i    (wl_c),
    .bclk_inv_i(inv_c),
    .lr_inv_i  (lri_c),
    .bclk_i    (bclk),
    .lrclk_i   (lrclk),
    .sdata_i   (sdata),
    .left_o    (left_o),
    .right_o   (right_o),
    .valid_o   (valid_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wl_num(input logic [1:0] c);
    case (c)
      2'b00:   return 16;
      2'b01:   return 20;
      2'b10:   return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] top_mask(input int n);
    return ~32'h0 << (32 - n);
  endfunction

  function automatic bit fill_bit(input int k, input int s);
    return FILL[(s * 7 + k * 3) % 32];
  endfunction

  // Reference monitor, compared on every clock.
  always @(negedge clk) begin
    if (!rst_n) begin
      held_l = '0;
      held_r = '0;
    end else if (valid_o) begin
      n_valid++;
      if (exp_l.size() == 0) begin
        check(1'b0, "R9 unexpected valid", {31'h0, valid_o}, 32'h0);
      end else begin
        logic [31:0] el, er;
        el = exp_l.pop_front();
        er = exp_r.pop_front();
        check(left_o === el, {cur_req, " left"}, left_o, el);
        check(right_o === er, {cur_req, " right"}, right_o, er);
      end
      held_l = left_o;
      held_r = right_o;
    end else begin
      check(left_o === held_l, "R9 left held", left_o, held_l);
      check(right_o === held_r, "R9 right held", right_o, held_r);
    end
  end

  // One bit slot: pins change on the non-sampling edge, sampled on the other.
  task automatic slot(input bit lr, input bit d);
    bclk  = inv_c;
    lrclk = lr ^ lri_c;
    sdata = d;
    repeat (4) @(negedge clk);
    bclk = ~inv_c;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(input logic [31:0] lv, input logic [31:0] rv, input int k);
    int n, h, o;
    n = wl_num(wl_c);
    h = h_c;
    o = h - n;
    exp_l.push_back(lv & top_mask(n));
    exp_r.push_back(rv & top_mask(n));
    case (fmt_c)
      2'b01: begin
        for (int j = 0; j < h; j++) slot(1'b1, (j < n) ? lv[31-j] : fill_bit(k, j));
        for (int j = 0; j < h; j++) slot(1'b0, (j < n) ? rv[31-j] : fill_bit(k, j + 1));
      end
      2'b00: begin
        for (int j = 0; j < h; j++) slot(1'b1, (j >= o) ? lv[31-(j-o)] : fill_bit(k, j));
        for (int j = 0; j < h; j++) slot(1'b0, (j >= o) ? rv[31-(j-o)] : fill_bit(k, j + 2));
      end
      2'b10: begin
        for (int j = 0; j < h; j++) slot(1'b0, (j >= 1 && j <= n) ? lv[31-(j-1)] : fill_bit(k, j));
        for (int j = 0; j < h; j++) slot(1'b1, (j >= 1 && j <= n) ? rv[31-(j-1)] : fill_bit(k, j + 3));
      end
      default: begin
        for (int j = 0; j < 2 * h; j++) begin
          bit d;
          if (j >= 1 && j <= n)          d = lv[31-(j-1)];
          else if (j > n && j <= 2 * n)  d = rv[31-(j-1-n)];
          else                           d = fill_bit(k, j);
          slot(j == 0, d);
        end
      end
    endcase
  endtask

  task automatic run_cfg(input logic [1:0] f, input logic [1:0] wl, input bit inv,
                         input bit lri, input int h, input int frames, input string req);
    bit idle_lr, first_lr;
    rst_n = 1'b0;
    @(negedge clk);
    check(valid_o === 1'b0, "R1 valid in reset", {31'h0, valid_o}, 32'h0);
    check(left_o === 32'h0 && right_o === 32'h0, "R1 samples in reset", left_o | right_o, 32'h0);
    fmt_c = f; wl_c = wl; inv_c = inv; lri_c = lri; h_c = h;
    idle_lr  = (f == 2'b10);
    first_lr = (f != 2'b10);
    exp_l.delete();
    exp_r.delete();
    bclk  = inv;
    lrclk = idle_lr ^ lri;
    sdata = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(valid_o === 1'b0 && left_o === 32'h0, "R1 after release", left_o, 32'h0);
    cur_req = req;
    n_valid = 0;
    slot(idle_lr, 1'b0);
    slot(idle_lr, 1'b1);
    for (int k = 0; k < frames; k++) begin
      logic [31:0] lv, rv;
      frame_id++;
      lv = 32'h6A09_E667 ^ (frame_id * 32'h9E37_79B9);
      rv = 32'hBB67_AE85 ^ (frame_id * 32'h7F4A_7C15);
      send_frame(lv, rv, frame_id);
    end
    slot(first_lr, 1'b0);
    slot(first_lr, 1'b0);
    repeat (10) @(negedge clk);
    check(exp_l.size() == 0, {"R9 pending pairs ", req}, exp_l.size(), 32'h0);
    check(n_valid == frames, {"R9 one valid per frame ", req}, n_valid, frames);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(valid_o === 1'b0 && left_o === 32'h0 && right_o === 32'h0, "R1 initial reset", left_o, 32'h0);
    run_cfg(2'b01, 2'b10, 1'b0, 1'b0, 32, 3, "R2");
    run_cfg(2'b01, 2'b00, 1'b0, 1'b0, 24, 3, "R10");
    run_cfg(2'b10, 2'b10, 1'b0, 1'b0, 32, 3, "R3");
    run_cfg(2'b10, 2'b11, 1'b0, 1'b0, 33, 2, "R6");
    run_cfg(2'b00, 2'b01, 1'b0, 1'b0, 32, 3, "R4");
    run_cfg(2'b00, 2'b00, 1'b0, 1'b0, 16, 3, "R4");
    run_cfg(2'b11, 2'b10, 1'b0, 1'b0, 32, 3, "R5");
    run_cfg(2'b11, 2'b00, 1'b0, 1'b0, 20, 3, "R5");
    run_cfg(2'b01, 2'b10, 1'b1, 1'b0, 32, 3, "R7");
    run_cfg(2'b10, 2'b01, 1'b1, 1'b0, 24, 3, "R7");
    run_cfg(2'b01, 2'b11, 1'b0, 1'b1, 32, 2, "R8");
    run_cfg(2'b11, 2'b01, 1'b0, 1'b1, 24, 3, "R8");
    run_cfg(2'b00, 2'b10, 1'b1, 1'b1, 28, 3, "R8");
    rst_n = 1'b0;
    @(negedge clk);
    check(valid_o === 1'b0 && left_o === 32'h0 && right_o === 32'h0, "R1 final reset", left_o | right_o, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule